// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port. It sits on a simple internal register bus and drives, for each pad, an output enable, an output value and a pull-up enable. Three registers are writable: a direction register that cannot be read back, an output data register and a pull-up register. A fourth address returns the pin levels after they pass through a synchronizer.

A chip operating-mode input decides who owns the pins. In single-chip mode the register contents control the pads. In the expanded-bus modes the port carries the external data bus instead. The direction bits are then ignored, and the bus controller's drive strobe turns all pads around together.

Two standby inputs set what happens to the register contents. Hardware standby clears the registers. Software standby keeps them and blocks bus writes.

Top module: `modal_gpio_port`

## Requirements
- R1: While reset is asserted, the direction, data and pull-up registers hold 0x00, and `pad_oe` and `pad_pu` are all zero.
- R2: A read at offset 0 (direction) always returns 0xFF, whatever the register holds.
- R3: In single-chip mode (`single_chip`=1), `pad_oe` equals the direction register (1 = output) and `pad_out` equals the data register.
- R4: A read at offset 1 returns the latched data register for every bit, whatever the direction setting.
- R5: A read at offset 2 returns `pad_in` as it was two clock edges earlier, through a two-flop synchronizer that resets to zero.
- R6: The pull-up register at offset 3 is read/write. In single-chip mode, `pad_pu[i]` is 1 exactly when pull-up bit i is 1 and direction bit i is 0.
- R7: In expanded mode (`single_chip`=0), the direction register is ignored. `pad_oe` is all ones when `xbus_drive`=1 and all zeros otherwise, `pad_out` equals `xbus_wdata`, and `pad_pu` is all zeros.
- R8: While `hw_stby`=1, the three registers are cleared at each clock edge, and a bus write in the same cycle is lost.
- R9: While `sw_stby`=1, with `hw_stby`=0, the registers keep their values and bus writes are ignored.
- R10: `xbus_rdata` equals `pad_in` combinationally, in every mode.
- R11: A write to offset 2 (pin read) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_chip | input | 1 | 1 = single-chip mode, 0 = expanded-bus mode |
| hw_stby | input | 1 | Hardware standby: clears registers |
| sw_stby | input | 1 | Software standby: holds registers, blocks writes |
| reg_addr | input | 2 | Register offset: 0 direction, 1 data, 2 pin, 3 pull-up |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for the addressed register |
| xbus_drive | input | 1 | Bus controller drives pads outward (expanded mode) |
| xbus_wdata | input | WIDTH | Bus data to send out on the pads |
| xbus_rdata | output | WIDTH | Pad levels returned to the bus controller |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |

## Verification
The bench builds the port with its defaults, WIDTH=8 and SYNC_STAGES=2. At these values a byte-wide reference model can track all three registers and the two-deep pin delay exactly. This lets directed sequences set up mixed direction and pull-up patterns, so that each pad bit can be observed with a different owner. A random phase then switches the mode, the standby inputs and the writes from cycle to cycle. It covers write attempts during either standby and mode changes while the pads are being driven.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFS_DIR  = 2'd0,
        OFS_DATA = 2'd1,
        OFS_PIN  = 2'd2,
        OFS_PULL = 2'd3
    } reg_ofs_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]          wr_data,
    output logic [W-1:0]          dir_o,
    output logic [W-1:0]          data_o,
    output logic [W-1:0]          pull_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] data;
        logic [W-1:0] pull;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hw_stby) begin
            r_d = '0;
        end else if (wr_en && !sw_stby) begin
            case (reg_ofs_e'(wr_addr))
                OFS_DIR:  r_d.dir  = wr_data;
                OFS_DATA: r_d.data = wr_data;
                OFS_PULL: r_d.pull = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_o  = r_q.dir;
    assign data_o = r_q.data;
    assign pull_o = r_q.pull;
endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux #(
    parameter int W = 8
) (
    input  logic         single_chip,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic [W-1:0] pull,
    input  logic         bus_drive,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (single_chip) begin
                oe[i]  = dir[i];
                out[i] = data[i];
                pu[i]  = pull[i] & ~dir[i];
            end else begin
                oe[i]  = bus_drive;
                out[i] = bus_wdata[i];
                pu[i]  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/modal_gpio_port.sv
module modal_gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  single_chip,
    input  logic                  hw_stby,
    input  logic                  sw_stby,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [WIDTH-1:0]      reg_wdata,
    output logic [WIDTH-1:0]      reg_rdata,
    input  logic                  xbus_drive,
    input  logic [WIDTH-1:0]      xbus_wdata,
    output logic [WIDTH-1:0]      xbus_rdata,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pu
);
    logic [WIDTH-1:0] dir_q, data_q, pull_q, pin_sync;

    gpio_port_regs #(.W(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .dir_o   (dir_q),
        .data_o  (data_q),
        .pull_o  (pull_q)
    );

    gpio_port_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_port_padmux #(.W(WIDTH)) u_mux (
        .single_chip (single_chip),
        .dir         (dir_q),
        .data        (data_q),
        .pull        (pull_q),
        .bus_drive   (xbus_drive),
        .bus_wdata   (xbus_wdata),
        .oe          (pad_oe),
        .out         (pad_out),
        .pu          (pad_pu)
    );

    // Direction register is write-only: a fixed pattern stands in for it.
    always_comb begin
        case (reg_ofs_e'(reg_addr))
            OFS_DIR:  reg_rdata = '1;
            OFS_DATA: reg_rdata = data_q;
            OFS_PIN:  reg_rdata = pin_sync;
            default:  reg_rdata = pull_q;
        endcase
    end

    assign xbus_rdata = pad_in;
endmodule

// File: rtl/gpio_port_checks.sv
module gpio_port_checks #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         single_chip,
    input logic         hw_stby,
    input logic         sw_stby,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_rdata,
    input logic         xbus_drive,
    input logic [W-1:0] xbus_wdata,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu
);
    logic [SYNC_STAGES-1:0][W-1:0] dly_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            dly_q[0] <= pad_in;
            for (int i = 1; i < SYNC_STAGES; i++) dly_q[i] <= dly_q[i-1];
            seen_q <= 1'b1;
        end
    end

    p_dir_reads_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd0 |-> reg_rdata == '1);

    p_pin_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd2 |-> reg_rdata == dly_q[SYNC_STAGES-1]);

    p_pu_never_on_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        single_chip |-> (pad_pu & pad_oe) == '0);

    p_expanded_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !single_chip |-> pad_pu == '0 && pad_out == xbus_wdata
                         && pad_oe == {W{xbus_drive}});

    p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(hw_stby) && single_chip |-> pad_oe == '0 && pad_pu == '0);

    p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(sw_stby) && !$past(hw_stby) && single_chip && $past(single_chip)
        |-> $stable(pad_oe) && $stable(pad_out));
endmodule

bind modal_gpio_port gpio_port_checks #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_chip (single_chip),
    .hw_stby     (hw_stby),
    .sw_stby     (sw_stby),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .xbus_drive  (xbus_drive),
    .xbus_wdata  (xbus_wdata),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu)
);

// File: tb/tb_modal_gpio_port.sv
module tb_modal_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       single_chip, hw_stby, sw_stby, reg_wr, xbus_drive;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, xbus_wdata, xbus_rdata;
    logic [7:0] pad_in, pad_out, pad_oe, pad_pu;

    always #5 clk = ~clk;

    modal_gpio_port dut (
        .clk(clk), .rst_n(rst_n), .single_chip(single_chip), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xbus_drive(xbus_drive), .xbus_wdata(xbus_wdata),
        .xbus_rdata(xbus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Behavioural reference model
    logic [7:0] m_dir, m_data, m_pull;
    logic [7:0] m_pins [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_data = 0; m_pull = 0;
            m_pins = '{8'h00, 8'h00};
        end else begin
            m_pins.push_back(pad_in);
            void'(m_pins.pop_front());
            if (hw_stby) begin
                m_dir = 0; m_data = 0; m_pull = 0;
            end else if (reg_wr && !sw_stby) begin
                if (reg_addr == 0) m_dir = reg_wdata;
                if (reg_addr == 1) m_data = reg_wdata;
                if (reg_addr == 3) m_pull = reg_wdata;
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cycle_check();
        logic [7:0] e_rd;
        case (reg_addr)
            2'd0: e_rd = 8'hFF;
            2'd1: e_rd = m_data;
            2'd2: e_rd = m_pins[0];
            default: e_rd = m_pull;
        endcase
        chk(reg_addr == 0 ? "R2 dir read" : reg_addr == 1 ? "R4 data read" :
            reg_addr == 2 ? "R5 pin read" : "R6 pull read", reg_rdata, e_rd);
        if (single_chip) begin
            chk("R3 pad_oe", pad_oe, m_dir);
            chk("R3 pad_out", pad_out, m_data);
            chk("R6 pad_pu", pad_pu, m_pull & ~m_dir);
        end else begin
            chk("R7 pad_oe", pad_oe, xbus_drive ? 8'hFF : 8'h00);
            chk("R7 pad_out", pad_out, xbus_wdata);
            chk("R7 pad_pu", pad_pu, 8'h00);
        end
        chk("R10 xbus_rdata", xbus_rdata, pad_in);
    endtask

    task automatic tick();
        @(negedge clk);
        cycle_check();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [1:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        rst_n = 0; single_chip = 1; hw_stby = 0; sw_stby = 0; reg_wr = 0;
        reg_addr = 0; reg_wdata = 0; xbus_drive = 0; xbus_wdata = 0; pad_in = 8'hC3;
        repeat (3) @(negedge clk);
        rd_expect(2'd1, 8'h00, "R1 data reset");
        rd_expect(2'd3, 8'h00, "R1 pull reset");
        chk("R1 pad_oe reset", pad_oe, 8'h00);
        chk("R1 pad_pu reset", pad_pu, 8'h00);
        rst_n = 1;
        tick();

        // Single-chip register control
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'h0F);
        wr(2'd3, 8'hFF);
        chk("R6 pull only on inputs", pad_pu, 8'hF0);
        rd_expect(2'd0, 8'hFF, "R2 write-only dir");
        rd_expect(2'd1, 8'hA5, "R4 data ignores dir");
        pad_in = 8'h3C;
        tick(); tick();
        rd_expect(2'd2, 8'h3C, "R5 two-edge pin delay");

        // Expanded mode hands pads to the bus
        single_chip = 0; xbus_drive = 1; xbus_wdata = 8'h96;
        tick();
        chk("R7 bus drives all", pad_oe, 8'hFF);
        xbus_drive = 0;
        tick();
        chk("R7 bus reads all", pad_oe, 8'h00);

        // Pin address is read-only
        wr(2'd2, 8'h77);
        rd_expect(2'd1, 8'hA5, "R11 data untouched");
        rd_expect(2'd3, 8'hFF, "R11 pull untouched");

        // Software standby holds contents
        single_chip = 1; sw_stby = 1;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
        sw_stby = 0;
        rd_expect(2'd1, 8'hA5, "R9 data held");
        chk("R9 dir held", pad_oe, 8'h0F);

        // Hardware standby clears, overriding a write
        hw_stby = 1;
        wr(2'd1, 8'h55);
        hw_stby = 0;
        rd_expect(2'd1, 8'h00, "R8 data cleared");
        rd_expect(2'd3, 8'h00, "R8 pull cleared");
        chk("R8 dir cleared", pad_oe, 8'h00);

        // Random traffic checked every cycle
        for (int n = 0; n < 2000; n++) begin
            single_chip = ($urandom_range(0, 3) != 0);
            hw_stby     = ($urandom_range(0, 31) == 0);
            sw_stby     = ($urandom_range(0, 5) == 0);
            reg_wr      = $urandom_range(0, 1);
            reg_addr    = 2'($urandom_range(0, 3));
            reg_wdata   = 8'($urandom);
            xbus_drive  = $urandom_range(0, 1);
            xbus_wdata  = 8'($urandom);
            pad_in      = 8'($urandom);
            tick();
        end
        reg_wr = 0; hw_stby = 0; sw_stby = 0;
        tick();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule